// File: doc/BRIEF.md
# Cache Identification Register Bank

This block is a small coprocessor-style register bank through which software learns the shape of the cache hierarchy. An access is presented in one cycle. It carries a valid strobe, a write flag, three selector fields (op1, CRm, op2) and 32 bits of write data. One clock edge later the bank answers with registered read data, a read-valid flag and an undefined-access flag.

Reads are indirect. A 4-bit selection register, written by software, picks one entry from a table of cache size descriptors. A separate level descriptor describes which cache levels exist. Both tables are loaded with constants at reset and are read-only afterwards. A core-version input tells the bank whether the newer-architecture behaviour is present. When that input is low, the selection register cannot be written and the descriptor reads return zero.

Any access that does not name one of the registers below is reported as undefined. This covers any other op1 value, other system-control registers and cache maintenance operations.

Top module: `cache_id_bank`

## Requirements
- R1: After a synchronous active-low reset, the selection register holds 0 and `rd_data`, `rd_valid` and `undef` are all 0.
- R2: A write with `new_arch`=1, op1=2, CRm=0 and op2=0 stores bits [3:0] of `wdata` into the selection register. A later read with op1=2, CRm=0, op2=0 returns that value zero-extended to 32 bits, whatever the state of `new_arch`.
- R3: Every other write is refused. This includes any write while `new_arch`=0. A refused write raises `undef` and leaves the selection register unchanged.
- R4: A read under op1=2 with op2≠0 or CRm≠0 is undefined.
- R5: A read with `new_arch`=1, op1=1, CRm=0, op2=0 returns the size descriptor chosen by the selection register. Index 0 gives 0xE007E01A (level-1 data), index 1 gives 0x2007E01A (level-1 instruction) and index 2 gives 0xF0000000 (no level-2 instruction cache).
- R6: A read with `new_arch`=1, op1=1, CRm=0, op2=1 returns the level descriptor 0x0A000003, which is (1<<27)|(2<<24)|3.
- R7: Under op1=1 with `new_arch`=1 and CRm=0, op2=7 reads as zero and any op2 other than 0, 1 or 7 is undefined. Under op1=1, a CRm other than 0 is undefined regardless of `new_arch`.
- R8: With `new_arch`=0, a read under op1=1 with CRm=0 returns zero with `rd_valid`=1 and `undef`=0, for every op2.
- R9: A selection value of 3 or more makes the size-descriptor read return zero.
- R10: An undefined access raises `undef` for exactly the one cycle that answers it, and `rd_data` is 0 in that cycle. Any op1 other than 1 or 2 is undefined.
- R11: Every response appears on the clock edge that samples the access. A read sets `rd_valid` for one cycle. Writes and idle cycles leave `rd_valid`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| new_arch | input | 1 | High when the core has the newer-architecture cache identification |
| acc_valid | input | 1 | Access present this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_op1 | input | 3 | First opcode selector |
| acc_crm | input | 4 | Secondary register selector |
| acc_op2 | input | 3 | Second opcode selector |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | One-cycle flag marking a read response |
| undef | output | 1 | One-cycle flag marking an undefined access |

## Verification
Each result is due on the first rising edge after the cycle in which the access is driven. A selection write affects only accesses driven in later cycles. The driver applies one access, or an idle cycle, per cycle on the falling edge and queues the response expected for that exact cycle. The monitor pops one entry 1 ns after every rising edge, so each comparison lands on the edge where the registered output changes. Idle entries between accesses confirm that `undef` and `rd_valid` fall back after one cycle.

// File: rtl/cid_pkg.sv
// Shared types for the cache identification bank.
// Assumes: the decoder and the top agree on this action encoding.
package cid_pkg;
    typedef enum logic [2:0] {
        ACT_NONE     = 3'd0,
        ACT_SEL_WR   = 3'd1,
        ACT_RD_SIZE  = 3'd2,
        ACT_RD_LEVEL = 3'd3,
        ACT_RD_ZERO  = 3'd4,
        ACT_RD_SEL   = 3'd5,
        ACT_UNDEF    = 3'd6
    } cid_act_t;
endpackage

// File: rtl/cid_decode.sv
// Access decoder: turns the selector fields of one access into a single action.
// Assumes: inputs are stable for the cycle; purely combinational.
module cid_decode
    import cid_pkg::*;
#(
    parameter int OP1_W = 3,
    parameter int CRM_W = 4,
    parameter int OP2_W = 3
) (
    input  logic             valid,
    input  logic             wr,
    input  logic             new_arch,
    input  logic [OP1_W-1:0] op1,
    input  logic [CRM_W-1:0] crm,
    input  logic [OP2_W-1:0] op2,
    output cid_act_t         act
);
    localparam logic [OP1_W-1:0] OP1_DESC = OP1_W'(1);
    localparam logic [OP1_W-1:0] OP1_SEL  = OP1_W'(2);

    // Classify the access into one action.
    always_comb begin
        act = ACT_NONE;
        if (valid) begin
            if (wr) begin
                if (new_arch && op1 == OP1_SEL && crm == '0 && op2 == '0)
                    act = ACT_SEL_WR;
                else
                    act = ACT_UNDEF;
            end else begin
                case (op1)
                    OP1_DESC: begin
                        if (crm != '0)
                            act = ACT_UNDEF;
                        else if (!new_arch)
                            act = ACT_RD_ZERO;
                        else begin
                            case (op2)
                                OP2_W'(0): act = ACT_RD_SIZE;
                                OP2_W'(1): act = ACT_RD_LEVEL;
                                OP2_W'(7): act = ACT_RD_ZERO;
                                default:   act = ACT_UNDEF;
                            endcase
                        end
                    end
                    OP1_SEL: begin
                        if (op2 == '0 && crm == '0)
                            act = ACT_RD_SEL;
                        else
                            act = ACT_UNDEF;
                    end
                    default: act = ACT_UNDEF;
                endcase
            end
        end
    end
endmodule

// File: rtl/cid_sel_reg.sv
// Selection register: holds the low SEL_W bits of the last accepted write.
// Assumes: wr_en is a single-cycle qualified write; synchronous active-low reset.
module cid_sel_reg #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [SEL_W-1:0]  sel_q
);
    // Capture the low bits on an accepted write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_en)
            sel_q <= wdata[SEL_W-1:0];
    end

    // R2: an accepted write lands its low bits exactly.
    assert_sel_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sel_q == $past(wdata[SEL_W-1:0]));
    // R3: without a write the selection never moves.
    assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel_q));
endmodule

// File: rtl/cid_desc_tab.sv
// Descriptor tables: size descriptors per selection index plus one level descriptor.
// Assumes: contents load at reset and never change; indices at or past NUM_SIZE read zero.
module cid_desc_tab #(
    parameter int DATA_W   = 32,
    parameter int SEL_W    = 4,
    parameter int NUM_SIZE = 3,
    parameter logic [NUM_SIZE*DATA_W-1:0] SIZE_INIT = '0,
    parameter logic [DATA_W-1:0] LEVEL_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] size_desc,
    output logic [DATA_W-1:0] level_desc
);
    localparam int SEL_SPAN = 1 << SEL_W;

    logic [DATA_W-1:0] tab_q [NUM_SIZE];
    logic [DATA_W-1:0] span  [SEL_SPAN];

    genvar i;
    generate
        for (i = 0; i < NUM_SIZE; i++) begin : g_ent
            // Load a size descriptor at reset; it is read-only afterwards.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    tab_q[i] <= SIZE_INIT[i*DATA_W +: DATA_W];
            end
        end
        for (i = 0; i < SEL_SPAN; i++) begin : g_span
            if (i < NUM_SIZE) begin : g_pop
                assign span[i] = tab_q[i];
            end else begin : g_empty
                assign span[i] = '0;
            end
        end
    endgenerate

    // Load the level descriptor at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_desc <= LEVEL_INIT;
    end

    // Choose the size descriptor named by the selection.
    always_comb size_desc = span[sel];
endmodule

// File: rtl/cache_id_bank.sv
// Top of the cache identification bank: decodes one access per cycle and
// registers the response.
// Assumes: one access per cycle, synchronous active-low reset, and the
// response is due on the edge that samples the access.
module cache_id_bank
    import cid_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int SEL_W    = 4,
    parameter int OP1_W    = 3,
    parameter int CRM_W    = 4,
    parameter int OP2_W    = 3,
    parameter int NUM_SIZE = 3,
    parameter logic [NUM_SIZE*DATA_W-1:0] SIZE_INIT =
        {32'hF000_0000, 32'h2007_E01A, 32'hE007_E01A},
    parameter logic [DATA_W-1:0] LEVEL_INIT = (32'd1 << 27) | (32'd2 << 24) | 32'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_arch,
    input  logic              acc_valid,
    input  logic              acc_wr,
    input  logic [OP1_W-1:0]  acc_op1,
    input  logic [CRM_W-1:0]  acc_crm,
    input  logic [OP2_W-1:0]  acc_op2,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              undef
);
    cid_act_t          act;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] size_desc;
    logic [DATA_W-1:0] level_desc;
    logic              is_read;

    cid_decode #(.OP1_W(OP1_W), .CRM_W(CRM_W), .OP2_W(OP2_W)) u_dec (
        .valid    (acc_valid),
        .wr       (acc_wr),
        .new_arch (new_arch),
        .op1      (acc_op1),
        .crm      (acc_crm),
        .op2      (acc_op2),
        .act      (act)
    );

    cid_sel_reg #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (act == ACT_SEL_WR),
        .wdata (wdata),
        .sel_q (sel_q)
    );

    cid_desc_tab #(
        .DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_SIZE(NUM_SIZE),
        .SIZE_INIT(SIZE_INIT), .LEVEL_INIT(LEVEL_INIT)
    ) u_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel_q),
        .size_desc  (size_desc),
        .level_desc (level_desc)
    );

    // Flag the actions that produce read data.
    always_comb is_read = (act == ACT_RD_SIZE) || (act == ACT_RD_LEVEL) ||
                          (act == ACT_RD_ZERO) || (act == ACT_RD_SEL);

    // Register the response for this cycle's access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            undef    <= 1'b0;
        end else begin
            undef    <= (act == ACT_UNDEF);
            rd_valid <= is_read;
            case (act)
                ACT_RD_SIZE:  rd_data <= size_desc;
                ACT_RD_LEVEL: rd_data <= level_desc;
                ACT_RD_SEL:   rd_data <= DATA_W'(sel_q);
                default:      rd_data <= '0;
            endcase
        end
    end

    // R10: an undefined response carries no data.
    assert_undef_nodata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (rd_data == '0 && !rd_valid));
    // R10: an undefined flag only answers an access from the previous cycle.
    assert_undef_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> $past(acc_valid));
    // R11: a read response follows a read access by one edge.
    assert_rd_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && !acc_wr));
    // R9: an unpopulated selection yields a zero size descriptor.
    assert_sel_oob_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_RD_SIZE && int'(sel_q) >= NUM_SIZE) |=> rd_data == '0);
    // R2: the selection never holds a value outside its width after a write.
    assert_sel_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_RD_SEL) |=> rd_data[DATA_W-1:SEL_W] == '0);
endmodule

// File: tb/cache_id_bank_test.sv
`timescale 1ns/1ps
module cache_id_bank_test;
    typedef struct {
        logic        rv;
        logic        ud;
        logic [31:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        new_arch = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_wr = 1'b0;
    logic [2:0]  acc_op1 = '0;
    logic [3:0]  acc_crm = '0;
    logic [2:0]  acc_op2 = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        undef;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    cache_id_bank uut (
        .clk(clk), .rst_n(rst_n), .new_arch(new_arch),
        .acc_valid(acc_valid), .acc_wr(acc_wr), .acc_op1(acc_op1),
        .acc_crm(acc_crm), .acc_op2(acc_op2), .wdata(wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .undef(undef)
    );

    task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got rv=%0b ud=%0b data=%08h, expected rv=%0b ud=%0b data=%08h",
                     tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
        end
    endtask

    // Monitor: compare one expected entry just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, {rd_valid, undef, rd_data}, {e.rv, e.ud, e.data});
        end
    end

    // Driver: apply one access on the falling edge and queue its response.
    task automatic acc(input logic na, input logic wr, input logic [2:0] o1,
                       input logic [3:0] cm, input logic [2:0] o2, input logic [31:0] wd,
                       input logic erv, input logic eud, input logic [31:0] ed,
                       input string tag);
        exp_t e;
        new_arch = na; acc_valid = 1'b1; acc_wr = wr;
        acc_op1 = o1; acc_crm = cm; acc_op2 = o2; wdata = wd;
        e.rv = erv; e.ud = eud; e.data = ed; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        acc_valid = 1'b0; acc_wr = 1'b0; wdata = '0;
    endtask

    task automatic idle(input string tag);
        exp_t e;
        acc_valid = 1'b0;
        e.rv = 1'b0; e.ud = 1'b0; e.data = '0; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset outputs", {rd_valid, undef, rd_data}, 34'd0);
        acc(1, 0, 2, 0, 0, 0, 1, 0, 32'h0, "R1 selection reset value");
        acc(1, 0, 1, 0, 0, 0, 1, 0, 32'hE007E01A, "R5 size entry 0");
        acc(1, 1, 2, 0, 0, 32'hFFFF_FFF1, 0, 0, 32'h0, "R11 write gives no read data");
        acc(1, 0, 2, 0, 0, 0, 1, 0, 32'h1, "R2 low 4 bits stored");
        acc(1, 0, 1, 0, 0, 0, 1, 0, 32'h2007E01A, "R5 size entry 1");
        acc(1, 1, 2, 0, 0, 32'h2, 0, 0, 32'h0, "R2 write 2");
        acc(1, 0, 1, 0, 0, 0, 1, 0, 32'hF0000000, "R5 size entry 2");
        acc(1, 0, 1, 0, 1, 0, 1, 0, 32'h0A000003, "R6 level descriptor");
        acc(1, 0, 1, 0, 7, 0, 1, 0, 32'h0, "R7 op2=7 reads zero");
        acc(1, 0, 1, 0, 3, 0, 0, 1, 32'h0, "R7 op2=3 undefined");
        idle("R10 undef drops after one cycle");
        acc(1, 0, 1, 5, 0, 0, 0, 1, 32'h0, "R7 nonzero CRm undefined");
        acc(1, 1, 2, 0, 0, 32'h5, 0, 0, 32'h0, "R9 write 5");
        acc(1, 0, 1, 0, 0, 0, 1, 0, 32'h0, "R9 index 5 reads zero");
        acc(1, 1, 2, 0, 0, 32'hF, 0, 0, 32'h0, "R9 write 15");
        acc(1, 0, 1, 0, 0, 0, 1, 0, 32'h0, "R9 index 15 reads zero");
        acc(1, 1, 2, 0, 0, 32'h1, 0, 0, 32'h0, "R2 write 1");
        acc(1, 1, 2, 0, 1, 32'h2, 0, 1, 32'h0, "R3 write with op2=1 refused");
        acc(1, 1, 2, 3, 0, 32'h2, 0, 1, 32'h0, "R3 write with CRm=3 refused");
        acc(1, 0, 2, 0, 0, 0, 1, 0, 32'h1, "R3 selection unchanged");
        acc(0, 0, 1, 0, 0, 0, 1, 0, 32'h0, "R8 size read zero when old core");
        acc(0, 0, 1, 0, 1, 0, 1, 0, 32'h0, "R8 level read zero when old core");
        acc(0, 0, 1, 0, 4, 0, 1, 0, 32'h0, "R8 other op2 zero when old core");
        acc(0, 1, 2, 0, 0, 32'h2, 0, 1, 32'h0, "R3 write refused when old core");
        acc(0, 0, 2, 0, 0, 0, 1, 0, 32'h1, "R2 selection readable on old core");
        acc(0, 0, 1, 2, 0, 0, 0, 1, 32'h0, "R7 nonzero CRm undefined on old core");
        acc(1, 0, 2, 0, 1, 0, 0, 1, 32'h0, "R4 op2=1 under op1=2");
        acc(1, 0, 2, 1, 0, 0, 0, 1, 32'h0, "R4 CRm=1 under op1=2");
        acc(1, 0, 0, 0, 0, 0, 0, 1, 32'h0, "R10 op1=0 undefined");
        acc(1, 0, 3, 0, 0, 0, 0, 1, 32'h0, "R10 op1=3 undefined");
        idle("R11 idle after undef");
        acc(1, 0, 1, 0, 0, 0, 1, 0, 32'h2007E01A, "R5 entry 1 again");
        idle("R11 idle gives no data");
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule